// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

The engine takes a byte stream from a serial receiver and places it into memory buffers. Software describes those buffers in a circular table of descriptors. Each descriptor is four 16-bit words: a status word, a length word and a 32-bit buffer pointer. The engine reads each descriptor through a simple word-addressed memory port that returns read data in the same cycle. It accepts bytes until the buffer holds the configured maximum length. It then writes back the received length and the status word, and moves on to the next descriptor.

Software owns a descriptor while its empty bit is clear and hands it to the engine by setting that bit. A wrap bit in a descriptor ends the ring, so the table has no size register. A continuous-mode bit lets the engine keep a descriptor and fill the same buffer again on the next pass. A receiver fault closes the buffer at once and always returns ownership to software. A full buffer whose interrupt bit is set raises a sticky event flag, which can drive an interrupt output.

Status bits are numbered from the most significant bit. Status bit k of the description is port bit 15-k of the 16-bit word.

Top module: `rxr_engine`

## Requirements
- R1: Descriptor n starts at word address `ring_base + 4*n`. Its status word sits at offset 0, its length at offset 1, the upper pointer half at offset 2 and the lower half at offset 3. The engine reads the status word first and uses the descriptor only if the empty bit (word bit 15) is 1. It then reads offset 2 and then offset 3.
- R2: After closing a descriptor whose wrap bit (word bit 13) is 1, the next status fetch is at `ring_base`. Otherwise it is at the following descriptor, 4 words further on. No other setting limits the ring length.
- R3: The k-th accepted byte of a buffer goes to byte address `ptr+k`, which is word address `(ptr+k)>>1`. The byte is placed in both halves of `mem_wdata`. `mem_wstrb` is 2'b10 for an even byte address and 2'b01 for an odd one. The buffer closes when the count reaches `max_len`. The count is written to offset 1 with strobe 2'b11, and the status word is written in the next cycle.
- R4: The event flag is set only when a buffer closes full and its interrupt bit (word bit 12) is 1. A close with that bit clear, or a close caused by a fault, leaves the flag unchanged.
- R5: `evt_flag` stays set until a cycle with `evt_clear` high clears it. If a new event and `evt_clear` fall in the same cycle, the flag stays set.
- R6: `irq` is high exactly when `evt_flag` and `irq_enable` are both high.
- R7: When continuous mode (word bit 9) is 1 and the buffer closes full, the written status keeps the empty bit at 1. The engine then fills the same buffer again when the ring comes back to that descriptor.
- R8: When `rx_overrun` or `rx_error` is high while the engine is receiving, the buffer closes at once with the bytes stored so far. A byte accepted in the same cycle is stored and counted first. The written empty bit is 0 whatever the continuous-mode bit holds, and `rx_overrun` also sets the overrun bit (word bit 1).
- R9: The written status word copies the wrap, interrupt and continuous-mode bits it was fetched with. The reserved bits (mask 16'h4DFD) are written as 0.
- R10: While the fetched status word has its empty bit at 0, `busy` is high and `rx_ready` is low. The engine then reads the same status word every cycle and makes no memory write until software sets the bit.
- R11: After reset `rx_ready`, `busy` and `evt_flag` are low, and the first fetch is at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 31 | Word address of the first descriptor |
| max_len | input | 16 | Byte count that fills a buffer |
| irq_enable | input | 1 | Lets the event flag drive `irq` |
| evt_clear | input | 1 | Write-one-to-clear strobe for the event flag |
| rx_valid | input | 1 | Receive byte present |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_overrun | input | 1 | Receiver overrun indication |
| rx_error | input | 1 | Receiver error indication |
| busy | output | 1 | Stalled on a descriptor that software still owns |
| evt_flag | output | 1 | Sticky receive event flag |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 31 | Word address |
| mem_wstrb | output | 2 | Byte lane strobes, bit 1 for the upper byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |

## Verification
The close of a full buffer with its interrupt bit set can land in the same cycle as a software clear of the event flag. The bench raises `evt_clear` in exactly the cycle it sees the status write go out, and then expects the flag to read 1. A second collision is a fault in the cycle that also accepts a byte, or a fault that meets continuous mode. These are judged by the exact length and status words the scoreboard expects, and the written empty bit must be 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int B_EMPTY = 15;
    localparam int B_WRAP  = 13;
    localparam int B_INTR  = 12;
    localparam int B_CONT  = 9;
    localparam int B_OVR   = 1;
    localparam logic [15:0] RSV_MASK = 16'h4DFD;

    localparam int OFS_LEN = 1;
    localparam int OFS_PHI = 2;
    localparam int OFS_PLO = 3;
    localparam int DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_PHI,
        ST_PLO,
        ST_RECV,
        ST_WLEN,
        ST_WSTAT
    } state_e;

    typedef struct packed {
        logic wrap;
        logic intr;
        logic cont;
    } dflags_t;

    function automatic logic [15:0] mk_status(logic empty, dflags_t f, logic ovr);
        logic [15:0] s;
        s = '0;
        s[B_EMPTY] = empty;
        s[B_WRAP]  = f.wrap;
        s[B_INTR]  = f.intr;
        s[B_CONT]  = f.cont;
        s[B_OVR]   = ovr;
        return s;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW = 31,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] desc_addr
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_addr <= base;
        end else if (advance) begin
            desc_addr <= wrap ? base : desc_addr + STEP_W;
        end
    end
endmodule

// File: rtl/rxr_event.sv
module rxr_event (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clear,
    input  logic enable,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag & enable;
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
    parameter int PW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-2:0] ring_base,
    input  logic [LW-1:0] max_len,
    input  logic          irq_enable,
    input  logic          evt_clear,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    output logic          rx_ready,
    input  logic          rx_overrun,
    input  logic          rx_error,
    output logic          busy,
    output logic          evt_flag,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [PW-2:0] mem_addr,
    output logic [1:0]    mem_wstrb,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    import rxr_pkg::*;

    localparam int AW = PW - 1;

    state_e        state_q;
    dflags_t       flags_q;
    logic [PW-1:0] ptr_q;
    logic [LW-1:0] cnt_q;
    logic          ovr_q;
    logic          fault_q;

    logic [AW-1:0] desc_addr;
    logic          advance;
    logic          evt_set;
    logic [PW-1:0] byte_addr;
    logic [LW-1:0] cnt_inc;
    logic          take;
    logic          fault_now;
    logic          close_now;

    rxr_ring_ptr #(.AW(AW), .STEP(DESC_WORDS)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .base      (ring_base),
        .advance   (advance),
        .wrap      (flags_q.wrap),
        .desc_addr (desc_addr)
    );

    rxr_event u_evt (
        .clk    (clk),
        .rst    (rst),
        .set    (evt_set),
        .clear  (evt_clear),
        .enable (irq_enable),
        .flag   (evt_flag),
        .irq    (irq)
    );

    assign byte_addr = ptr_q + PW'(cnt_q);
    assign take      = (state_q == ST_RECV) && rx_valid;
    assign fault_now = (state_q == ST_RECV) && (rx_overrun || rx_error);
    assign cnt_inc   = cnt_q + LW'(take);
    assign close_now = fault_now || (take && (cnt_inc >= max_len));
    assign advance   = (state_q == ST_WSTAT);
    assign evt_set   = (state_q == ST_WSTAT) && flags_q.intr && !fault_q;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wstrb = 2'b00;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req = 1'b1;
                busy    = !mem_rdata[B_EMPTY];
            end
            ST_PHI: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_PHI);
            end
            ST_PLO: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_PLO);
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                if (take) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr[PW-1:1];
                    mem_wstrb = byte_addr[0] ? 2'b01 : 2'b10;
                    mem_wdata = {rx_byte, rx_byte};
                end
            end
            ST_WLEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(OFS_LEN);
                mem_wstrb = 2'b11;
                mem_wdata = 16'(cnt_q);
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wstrb = 2'b11;
                mem_wdata = mk_status(flags_q.cont && !fault_q, flags_q, ovr_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            flags_q <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (mem_rdata[B_EMPTY]) begin
                        flags_q <= '{wrap: mem_rdata[B_WRAP],
                                     intr: mem_rdata[B_INTR],
                                     cont: mem_rdata[B_CONT]};
                        state_q <= ST_PHI;
                    end
                end
                ST_PHI: begin
                    ptr_q[PW-1:16] <= mem_rdata[PW-17:0];
                    state_q        <= ST_PLO;
                end
                ST_PLO: begin
                    ptr_q[15:0] <= mem_rdata;
                    cnt_q       <= '0;
                    ovr_q       <= 1'b0;
                    fault_q     <= 1'b0;
                    state_q     <= ST_RECV;
                end
                ST_RECV: begin
                    cnt_q <= cnt_inc;
                    if (close_now) begin
                        fault_q <= fault_now;
                        ovr_q   <= rx_overrun;
                        state_q <= ST_WLEN;
                    end
                end
                ST_WLEN:  state_q <= ST_WSTAT;
                ST_WSTAT: state_q <= ST_FETCH;
                default:  state_q <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk
    import rxr_pkg::*;
#(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst,
    input state_e        state_q,
    input dflags_t       flags_q,
    input logic          fault_q,
    input logic [PW-2:0] ring_base,
    input logic          busy,
    input logic          rx_ready,
    input logic          mem_we,
    input logic [PW-2:0] mem_addr,
    input logic [15:0]   mem_wdata,
    input logic          evt_flag,
    input logic          evt_clear,
    input logic          irq,
    input logic          irq_enable
);
    // R2: a closed wrap descriptor sends the next fetch to the ring base
    a_r2_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WSTAT && flags_q.wrap) |=> (state_q == ST_FETCH && mem_addr == ring_base));

    // R3: the length write is followed at once by the status write
    a_r3_len_then_status: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WLEN) |=> (state_q == ST_WSTAT && mem_we));

    // R4: the event flag rises only out of a status close
    a_r4_event_source: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_flag) |-> $past(state_q == ST_WSTAT));

    // R5: the flag holds while no clear arrives
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !evt_clear) |=> evt_flag);

    // R6: the interrupt needs both the flag and the enable
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt_flag && irq_enable));

    // R8: a fault close always hands the descriptor back
    a_r8_fault_clears_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WSTAT && fault_q) |-> !mem_wdata[B_EMPTY]);

    // R9: reserved status bits are written as zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WSTAT) |-> ((mem_wdata & RSV_MASK) == 16'h0000));

    // R10: a stall takes no data and writes nothing
    a_r10_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!rx_ready && !mem_we));
endmodule

bind rxr_engine rxr_engine_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .flags_q    (flags_q),
    .fault_q    (fault_q),
    .ring_base  (ring_base),
    .busy       (busy),
    .rx_ready   (rx_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .evt_flag   (evt_flag),
    .evt_clear  (evt_clear),
    .irq        (irq),
    .irq_enable (irq_enable)
);

// File: tb/tb_rxr_engine.sv
module tb_rxr_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] ring_base = 31'h20;
    logic [15:0] max_len = 16'd3;
    logic        irq_enable = 1'b0;
    logic        evt_clear = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_ready;
    logic        rx_overrun = 1'b0;
    logic        rx_error = 1'b0;
    logic        busy, evt_flag, irq;
    logic        mem_req, mem_we;
    logic [30:0] mem_addr;
    logic [1:0]  mem_wstrb;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] mem [0:1023];

    typedef struct {
        logic [30:0] addr;
        logic [15:0] data;
        logic [1:0]  strb;
        string       tag;
    } wr_t;
    wr_t expq[$];

    always #5 clk = ~clk;

    rxr_engine dut (
        .clk(clk), .rst(rst), .ring_base(ring_base), .max_len(max_len),
        .irq_enable(irq_enable), .evt_clear(evt_clear), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .rx_error(rx_error), .busy(busy), .evt_flag(evt_flag), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (!rst && mem_req && mem_we) begin
            if (mem_wstrb[1]) mem[mem_addr[9:0]][15:8] = mem_wdata[15:8];
            if (mem_wstrb[0]) mem[mem_addr[9:0]][7:0]  = mem_wdata[7:0];
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            summary();
            $finish;
        end
    end

    // scoreboard monitor: every memory write is compared with the queue head
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL unexpected write: actual addr %h data %h strb %b expected none",
                         mem_addr, mem_wdata, mem_wstrb);
            end else begin
                wr_t e;
                e = expq.pop_front();
                if (e.addr != mem_addr || e.data != mem_wdata || e.strb != mem_wstrb) begin
                    errors++;
                    $display("FAIL %s: actual addr %h data %h strb %b expected addr %h data %h strb %b",
                             e.tag, mem_addr, mem_wdata, mem_wstrb, e.addr, e.data, e.strb);
                end
            end
        end
    end

    task automatic check(input logic cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic exp_wr(input logic [30:0] a, input logic [15:0] d, input logic [1:0] s, input string tag);
        wr_t e;
        e.addr = a; e.data = d; e.strb = s; e.tag = tag;
        expq.push_back(e);
    endtask

    // R3: byte lane rule
    task automatic exp_byte(input logic [31:0] ba, input logic [7:0] b, input string tag);
        exp_wr(ba[31:1], {b, b}, ba[0] ? 2'b01 : 2'b10, tag);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_fault(input logic ovr);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_overrun = ovr;
        rx_error   = !ovr;
        @(negedge clk);
        rx_overrun = 1'b0;
        rx_error   = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_desc(input int w, input logic [15:0] st, input logic [31:0] p);
        mem[w]     = st;
        mem[w + 1] = 16'h0;
        mem[w + 2] = p[31:16];
        mem[w + 3] = p[15:0];
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        set_desc(32'h20, 16'h9000, 32'h200);  // E,I
        set_desc(32'h24, 16'h8200, 32'h300);  // E,CM
        set_desc(32'h28, 16'hB200, 32'h401);  // E,W,I,CM, odd start
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state and first fetch at the base
        check(!rx_ready && !busy && !evt_flag, "R11 reset outputs", {rx_ready, busy, evt_flag}, 0);
        check(mem_addr == 31'h20, "R11 first fetch at base", mem_addr, 32'h20);

        // R1 R3 R4: full buffer with interrupt bit
        exp_byte(32'h200, 8'h11, "R3 byte0 even lane");
        exp_byte(32'h201, 8'h22, "R3 byte1 odd lane");
        exp_byte(32'h202, 8'h33, "R3 byte2");
        exp_wr(31'h21, 16'd3, 2'b11, "R3 length word");
        exp_wr(31'h20, 16'h1000, 2'b11, "R1 status close D0");
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        drain();
        check(evt_flag == 1'b1, "R4 event on full close", evt_flag, 1);
        check(irq == 1'b0, "R6 irq masked", irq, 0);
        irq_enable = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R6 irq enabled", irq, 1);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        check(evt_flag == 1'b0 && irq == 1'b0, "R5 write-one clear", evt_flag, 0);

        // R2 R7 R4: next descriptor, continuous mode, no interrupt bit
        exp_byte(32'h300, 8'hA0, "R2 next desc buffer");
        exp_byte(32'h301, 8'hA1, "R7 byte1");
        exp_byte(32'h302, 8'hA2, "R7 byte2");
        exp_wr(31'h25, 16'd3, 2'b11, "R7 length");
        exp_wr(31'h24, 16'h8200, 2'b11, "R7 empty kept by CM");
        send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2);
        drain();
        check(evt_flag == 1'b0, "R4 no event without I bit", evt_flag, 0);

        // R8: overrun after one byte, CM set but empty cleared
        exp_byte(32'h401, 8'hC1, "R8 byte before fault");
        exp_wr(31'h29, 16'd1, 2'b11, "R8 length at fault");
        exp_wr(31'h28, 16'h3202, 2'b11, "R8 overrun status");
        send_byte(8'hC1);
        pulse_fault(1'b1);
        drain();
        check(evt_flag == 1'b0, "R4 no event on fault close", evt_flag, 0);

        // R2 R10: wrap back to base, D0 owned by software
        check(mem_addr == 31'h20, "R2 wrap fetch address", mem_addr, 32'h20);
        check(busy == 1'b1 && rx_ready == 1'b0, "R10 stall on owned desc", {busy, rx_ready}, 2'b10);
        rx_valid = 1'b1; rx_byte = 8'hEE;
        repeat (5) @(negedge clk);
        check(busy == 1'b1 && mem_addr == 31'h20, "R10 still polling", busy, 1);
        rx_valid = 1'b0;

        // R9 R5: reserved bits set by software, clear collides with event
        exp_byte(32'h200, 8'h41, "R9 byte0");
        exp_byte(32'h201, 8'h42, "R9 byte1");
        exp_byte(32'h202, 8'h43, "R9 byte2");
        exp_wr(31'h21, 16'd3, 2'b11, "R9 length");
        exp_wr(31'h20, 16'h1000, 2'b11, "R9 reserved written zero");
        mem[32'h20] = 16'hDDFD;
        send_byte(8'h41); send_byte(8'h42); send_byte(8'h43);
        while (!(mem_we && mem_addr == 31'h20)) @(negedge clk);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        check(evt_flag == 1'b1, "R5 set wins over clear", evt_flag, 1);
        check(irq == 1'b1, "R6 irq follows flag", irq, 1);

        // R7 R8: CM descriptor reused, then error with no overrun bit
        exp_byte(32'h300, 8'h5A, "R7 buffer reused");
        exp_wr(31'h25, 16'd1, 2'b11, "R8 length at error");
        exp_wr(31'h24, 16'h0200, 2'b11, "R8 error clears empty");
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h5A; rx_error = 1'b1;  // same-cycle byte and fault
        @(negedge clk);
        rx_valid = 1'b0; rx_error = 1'b0;
        drain();
        check(busy == 1'b1, "R10 stall on D2 after reuse", busy, 1);
        check(expq.size() == 0, "R3 all writes seen", expq.size(), 0);

        summary();
        $finish;
    end
endmodule